// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides, cycle by cycle, which power resources of a serial interface chip are running. The chip has an asynchronous serial core clocked from an oscillator and a line driver supplied by a charge pump. The sequencer drives one enable for each of the two resources, an enable that cuts the host bus off from the core, an always-on receiver enable, a transmit-ready flag and a wake-up interrupt. The oscillator, the pump and the line circuits sit outside the block and are represented only by these signals.

A power mode can be requested in two ways. Software writes a 2-bit mode code. A hardware sleep pin forces the deepest mode. A separate auto-shutdown pin stops the pump whenever the oscillator is already off. A power-save pin isolates the host bus, but only while the oscillator is stopped.

The block wakes on receive-line activity, or on a host access that is not blocked by isolation, seen while the oscillator is off. Waking starts the oscillator first and the pump on a later edge. After the pump restarts, a parameterized settle count must run out before transmit is reported ready. Each return to full power raises an interrupt, which stays set until the host acknowledges it.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset `osc_en`=1, `pump_en`=1, `mode`=0, `tx_ready`=1, `wake_irq`=0 and `bus_iso`=0.
- R2: A write (`sw_we`=1) captures `sw_mode`, and the enables follow on the next clock edge. The codes are: 0 both on, 1 oscillator off and pump on, 2 oscillator on and pump off, 3 both off.
- R3: While `hw_sleep` is high, both enables are 0 from the following edge onward, whatever the software code or any wake event.
- R4: `mode` reports the running state: bit 0 is set when the oscillator is off, and bit 1 is set when the pump is off.
- R5: When `acp_pin` is high and the oscillator is off, the pump is off at the next edge. When the oscillator is running, `acp_pin` has no effect.
- R6: `bus_iso` equals `pwrsave` AND oscillator off. A host access while `bus_iso` is high is not a wake event.
- R7: A wake event (`rx_activity`, or `host_access` while not isolated, sampled while the oscillator is off) resets the software code to 0. When both resources must come on, the pump turns on no earlier than one edge after the oscillator.
- R8: Turning a resource off takes effect on the first edge after the request is seen. No ordering delay applies.
- R9: `tx_ready` is 0 while the pump is off. It goes to 1 exactly SETTLE_CYC edges after the edge on which `pump_en` rose.
- R10: `wake_irq` is set on the edge where the block returns to both-on from any other mode. It stays set until an edge that samples `int_ack`=1. If set and acknowledge fall on the same edge, set wins.
- R11: A software write and a wake event sampled on the same edge store the written code.
- R12: `rx_en` is 1 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_we | input | 1 | Software mode write strobe |
| sw_mode | input | 2 | Software mode code |
| hw_sleep | input | 1 | Hardware request for both-off mode |
| acp_pin | input | 1 | Pump auto-shutdown pin |
| pwrsave | input | 1 | Host bus isolation request |
| host_access | input | 1 | Host bus transaction seen |
| rx_activity | input | 1 | Receive-line activity seen |
| int_ack | input | 1 | Host read of interrupt status |
| osc_en | output | 1 | Oscillator enable |
| pump_en | output | 1 | Charge-pump enable |
| bus_iso | output | 1 | Host bus isolation enable |
| rx_en | output | 1 | Line receiver enable |
| tx_ready | output | 1 | Pump settled, transmit allowed |
| wake_irq | output | 1 | Wake-up interrupt |
| mode | output | 2 | Current power mode |

## Verification
Two pairs of events can land on the same clock edge. A software mode write can coincide with a wake event, and a new wake interrupt can coincide with the host acknowledge. Directed sequences hold `sw_we` together with `rx_activity` while the oscillator is off, and keep `int_ack` high across a wake. A long random phase then lets all inputs collide freely. The behavioural reference model in the bench decides every outcome, and it is compared against all outputs on every clock.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    // Software mode codes: bit 0 stops the oscillator, bit 1 stops the pump
    typedef enum logic [1:0] {
        MODE_ACTIVE   = 2'd0,
        MODE_OSC_OFF  = 2'd1,
        MODE_PUMP_OFF = 2'd2,
        MODE_FULL     = 2'd3
    } lpm_mode_e;

    typedef struct packed {
        logic      osc;
        logic      pump;
        lpm_mode_e sw_mode;
    } core_state_t;

endpackage

// File: rtl/lpm_target.sv
// Resolves the requested mode into the resources that should run.
module lpm_target
    import lpm_pkg::*;
(
    input  lpm_mode_e sw_mode,
    input  logic      hw_sleep,
    input  logic      acp_pin,
    input  logic      osc_q,
    output logic      osc_want,
    output logic      pump_want
);
    lpm_mode_e req;

    always_comb begin
        req       = hw_sleep ? MODE_FULL : sw_mode;
        osc_want  = ~req[0];
        // auto shutdown only bites when the core clock is already stopped
        pump_want = ~req[1] & ~(acp_pin & ~osc_q);
    end
endmodule

// File: rtl/lpm_settle.sv
// Counts pump settling cycles after the pump is re-enabled.
module lpm_settle #(
    parameter int SETTLE_CYC = 4500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pump_on,
    output logic tx_ready
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!pump_on)
            cnt_d = CW'(SETTLE_CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tx_ready = pump_on & (cnt_q == '0);
endmodule

// File: rtl/lpm_wake_irq.sv
// Sticky wake-up interrupt, set on return to full power.
module lpm_wake_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic full_on_q,
    input  logic full_on_d,
    input  logic int_ack,
    output logic irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = (full_on_d & ~full_on_q) | (irq_q & ~int_ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int SETTLE_CYC = 4500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_we,
    input  logic [1:0] sw_mode,
    input  logic       hw_sleep,
    input  logic       acp_pin,
    input  logic       pwrsave,
    input  logic       host_access,
    input  logic       rx_activity,
    input  logic       int_ack,
    output logic       osc_en,
    output logic       pump_en,
    output logic       bus_iso,
    output logic       rx_en,
    output logic       tx_ready,
    output logic       wake_irq,
    output logic [1:0] mode
);
    core_state_t s_d, s_q;
    logic        osc_want, pump_want;
    logic        iso_c, wake_c;

    lpm_target u_target (
        .sw_mode   (s_q.sw_mode),
        .hw_sleep  (hw_sleep),
        .acp_pin   (acp_pin),
        .osc_q     (s_q.osc),
        .osc_want  (osc_want),
        .pump_want (pump_want)
    );

    always_comb begin
        iso_c  = pwrsave & ~s_q.osc;
        wake_c = ~s_q.osc & (rx_activity | (host_access & ~iso_c));

        s_d = s_q;
        if (sw_we)
            s_d.sw_mode = lpm_mode_e'(sw_mode);
        else if (wake_c)
            s_d.sw_mode = MODE_ACTIVE;

        s_d.osc  = osc_want;
        // pump waits for a running oscillator whenever the oscillator is wanted
        s_d.pump = pump_want & (s_q.osc | ~osc_want);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.osc     <= 1'b1;
            s_q.pump    <= 1'b1;
            s_q.sw_mode <= MODE_ACTIVE;
        end else begin
            s_q <= s_d;
        end
    end

    lpm_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .pump_on  (s_q.pump),
        .tx_ready (tx_ready)
    );

    lpm_wake_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_on_q (s_q.osc & s_q.pump),
        .full_on_d (s_d.osc & s_d.pump),
        .int_ack   (int_ack),
        .irq       (wake_irq)
    );

    assign osc_en  = s_q.osc;
    assign pump_en = s_q.pump;
    assign bus_iso = iso_c;
    assign rx_en   = 1'b1;
    assign mode    = {~s_q.pump, ~s_q.osc};
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic osc_en,
    input logic pump_en,
    input logic bus_iso,
    input logic tx_ready,
    input logic wake_irq,
    input logic int_ack,
    input logic acp_pin,
    input logic hw_sleep
);
    p_pump_after_osc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_en && osc_en && !$past(pump_en)) |-> $past(osc_en));

    p_iso_only_asleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_iso |-> !osc_en);

    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq && !int_ack) |=> wake_irq);

    p_ready_needs_pump_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> pump_en);

    p_ready_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_en) |-> !tx_ready);

    p_acp_stops_pump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acp_pin && !osc_en) |=> !pump_en);

    p_hw_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hw_sleep |=> (!osc_en && !pump_en));
endmodule

bind lpm_sequencer lpm_sequencer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .pump_en  (pump_en),
    .bus_iso  (bus_iso),
    .tx_ready (tx_ready),
    .wake_irq (wake_irq),
    .int_ack  (int_ack),
    .acp_pin  (acp_pin),
    .hw_sleep (hw_sleep)
);

// File: tb/lpm_sequencer_tb_top.sv
module lpm_sequencer_tb_top;
    localparam int SETTLE = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_we = 0, hw_sleep = 0, acp_pin = 0, pwrsave = 0;
    logic host_access = 0, rx_activity = 0, int_ack = 0;
    logic [1:0] sw_mode = 0;
    logic osc_en, pump_en, bus_iso, rx_en, tx_ready, wake_irq;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit finished = 0;

    // behavioural reference state
    int m_osc, m_pump, m_sw, m_cnt, m_irq;

    always #5 clk = ~clk;

    lpm_sequencer #(.SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_mode(sw_mode),
        .hw_sleep(hw_sleep), .acp_pin(acp_pin), .pwrsave(pwrsave),
        .host_access(host_access), .rx_activity(rx_activity), .int_ack(int_ack),
        .osc_en(osc_en), .pump_en(pump_en), .bus_iso(bus_iso), .rx_en(rx_en),
        .tx_ready(tx_ready), .wake_irq(wake_irq), .mode(mode)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_osc = 1; m_pump = 1; m_sw = 0; m_cnt = 0; m_irq = 0;
        end else begin
            int req, want_o, want_p, n_osc, n_pump, n_sw, n_cnt, was_on, is_on, woke;
            woke = (m_osc == 0) && (rx_activity || (host_access && !(pwrsave && m_osc == 0)));
            req = hw_sleep ? 3 : m_sw;
            want_o = (req % 2 == 0);
            want_p = (req < 2) && !(acp_pin && m_osc == 0);
            n_osc = want_o;
            n_pump = want_p && (m_osc == 1 || !want_o);
            if (sw_we) n_sw = sw_mode;
            else if (woke) n_sw = 0;
            else n_sw = m_sw;
            if (m_pump == 0) n_cnt = SETTLE;
            else n_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
            was_on = m_osc && m_pump;
            is_on = n_osc && n_pump;
            if (is_on && !was_on) m_irq = 1;
            else if (int_ack) m_irq = 0;
            m_osc = n_osc; m_pump = n_pump; m_sw = n_sw; m_cnt = n_cnt;
        end
        started = 1;
    end

    // compare every output shortly after each edge
    always @(posedge clk) begin
        #3;
        if (started && !finished) begin
            check("R2/R3/R7/R8/R11 osc_en", osc_en, m_osc);
            check("R2/R3/R5/R7/R8 pump_en", pump_en, m_pump);
            check("R4 mode", mode, (m_pump ? 0 : 2) + (m_osc ? 0 : 1));
            check("R6 bus_iso", bus_iso, (pwrsave && m_osc == 0) ? 1 : 0);
            check("R9 tx_ready", tx_ready, (m_pump && m_cnt == 0) ? 1 : 0);
            check("R10 wake_irq", wake_irq, m_irq);
            check("R12 rx_en", rx_en, 1);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(int code);
        sw_mode = code[1:0]; sw_we = 1;
        cyc(1);
        sw_we = 0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        check("R1 osc_en", osc_en, 1);
        check("R1 pump_en", pump_en, 1);
        check("R1 tx_ready", tx_ready, 1);
        check("R1 wake_irq", wake_irq, 0);

        // R2 each software code, R8 immediate shutdown
        write_mode(1); cyc(2);
        check("R2 code1 osc", osc_en, 0);
        write_mode(2); cyc(3);
        check("R2 code2 pump", pump_en, 0);
        write_mode(3); cyc(3);
        check("R4 full mode", mode, 3);
        write_mode(0); cyc(4);
        check("R7 osc back", osc_en, 1);
        cyc(SETTLE + 2);
        check("R9 ready after settle", tx_ready, 1);
        check("R10 irq pending", wake_irq, 1);
        int_ack = 1; cyc(1); int_ack = 0; cyc(1);
        check("R10 irq cleared", wake_irq, 0);

        // R5 auto shutdown
        acp_pin = 1; cyc(3);
        check("R5 no effect while running", pump_en, 1);
        write_mode(1); cyc(3);
        check("R5 pump stopped", pump_en, 0);
        acp_pin = 0;
        // R7 wake by rx activity
        rx_activity = 1; cyc(1); rx_activity = 0; cyc(4 + SETTLE);
        check("R7 awake by rx", mode, 0);
        int_ack = 1; cyc(1); int_ack = 0;

        // R3 hardware pin holds sleep over wake events
        hw_sleep = 1; cyc(2);
        host_access = 1; cyc(1); host_access = 0; cyc(3);
        check("R3 pin holds", mode, 3);
        hw_sleep = 0; cyc(4);
        check("R3 release", mode, 0);

        // R6 isolation blocks host wake, rx still wakes
        pwrsave = 1;
        write_mode(3); cyc(2);
        check("R6 isolated", bus_iso, 1);
        host_access = 1; cyc(2); host_access = 0; cyc(2);
        check("R6 host ignored", mode, 3);
        // R10 set and ack in the same cycle: ack held across wake
        int_ack = 1;
        rx_activity = 1; cyc(1); rx_activity = 0; cyc(4);
        int_ack = 0; pwrsave = 0;
        cyc(SETTLE + 2);

        // R11 write beats simultaneous wake
        write_mode(1); cyc(2);
        sw_mode = 3; sw_we = 1; rx_activity = 1; cyc(1);
        sw_we = 0; rx_activity = 0; cyc(3);
        check("R11 write wins", mode, 3);
        write_mode(0); cyc(SETTLE + 4);

        // random collisions
        for (int i = 0; i < 4000; i++) begin
            sw_we       = ($urandom % 19 == 0);
            sw_mode     = 2'($urandom % 4);
            host_access = ($urandom % 29 == 0);
            rx_activity = ($urandom % 37 == 0);
            int_ack     = ($urandom % 11 == 0);
            if ($urandom % 83 == 0) hw_sleep = ~hw_sleep;
            if ($urandom % 61 == 0) acp_pin = ~acp_pin;
            if ($urandom % 53 == 0) pwrsave = ~pwrsave;
            cyc(1);
        end
        cyc(2);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule